// File: doc/BRIEF.md
# Call and Return Frame Sequencer

This block runs the multi-cycle stack work behind subroutine entry, subroutine exit and the system-call trap of a 32-bit processor. The surrounding pipeline hands it the current program counter, the stack and frame pointers read from the register file, a jump target, a trap handler base and a trap code, and raises a start strobe with a two-bit operation select. The sequencer then walks a short series of single-word memory accesses over a request/acknowledge port and returns the new stack pointer, frame pointer and program counter on a one-cycle write-back strobe. A done pulse follows one cycle later.

Each call frame holds three words below the caller's stack pointer: an unused word reserved for a static chain at the top, the return address beneath it, and the saved frame pointer at the bottom. The bottom address becomes both the new stack pointer and the new frame pointer. A return works from the frame pointer alone, so the stack pointer the callee left behind does not matter. A trap always produces a special-register update carrying its cause and code. Only the all-ones code builds a frame and vectors to the handler base.

Top module: `call_frame_seq`

## Requirements
- R1: With `frame_op` = 2'b00 (call, absolute target), the block writes PC+6 to address SP-8 and then the old FP to address SP-12, in that order, with no other access.
- R2: With `frame_op` = 2'b01 (call through register), the block writes PC+2 to address SP-8 and then the old FP to SP-12, and the next PC is `jump_target`.
- R3: After either call, or the vectored trap, the new SP and new FP both equal the old SP minus 12. The next PC of an absolute call is `jump_target`.
- R4: With `frame_op` = 2'b10 (return), the block reads the word at FP and then the word at FP+4. The new FP is the first word, the next PC is the second, and the new SP is the old FP plus 12.
- R5: With `frame_op` = 2'b11 and a trap code of all ones, the block builds the same frame as R1 with return address PC+6, and the next PC is `vector_base`.
- R6: Every trap raises `sr_we` together with `wb_en`, with `sr_cause` = 3 and `sr_code` equal to the trap code. Any other operation leaves `sr_we` low. A trap whose code is not all ones makes no memory access, keeps SP and FP, and sets the next PC to PC+6.
- R7: Memory requests go out one at a time. A request is held, with address, write enable and write data steady, until `mem_ack` is sampled high. Every address is word aligned when SP and FP are. Bits 31:24 of a data word belong to the lowest byte address (big-endian).
- R8: `wb_en` is high for exactly one cycle, and `done` is high for exactly the following cycle.
- R9: A start strobe that arrives while an operation is in progress has no effect on that operation or on any later output.
- R10: During and right after reset, `mem_req`, `wb_en`, `sr_we` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_go | input | 1 | Start strobe, taken only when idle |
| frame_op | input | 2 | 00 absolute call, 01 register call, 10 return, 11 trap |
| cur_pc | input | 32 | Address of the current instruction |
| jump_target | input | 32 | Call destination (immediate or register value) |
| vector_base | input | 32 | Trap handler address |
| trap_code | input | 32 | Trap code |
| cur_sp | input | 32 | Stack pointer before the operation |
| cur_fp | input | 32 | Frame pointer before the operation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Read data |
| wb_en | output | 1 | Write-back strobe for the three results |
| wb_sp | output | 32 | New stack pointer |
| wb_fp | output | 32 | New frame pointer |
| wb_pc | output | 32 | Next program counter |
| sr_we | output | 1 | Special-register update strobe (trap only) |
| sr_cause | output | 32 | Trap cause value, 3 |
| sr_code | output | 32 | Trap code to record |
| done | output | 1 | One-cycle completion pulse |

## Verification
The alignment property assumes that the stack and frame pointers handed in are multiples of four. The handshake properties assume that memory raises `mem_ack` only while a request is pending and drops it after one cycle. The stimulus draws SP and FP only from word-aligned values in a small window. It also models a memory that acknowledges each pending request after a random zero to three cycle wait and pulses the acknowledge for a single cycle. The trap code is random, with the all-ones code injected often enough that both trap paths are exercised.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

   typedef enum logic [1:0] {
      OP_CALL_ABS = 2'b00,
      OP_CALL_REG = 2'b01,
      OP_RETURN   = 2'b10,
      OP_TRAP     = 2'b11
   } fseq_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_RA,
      ST_PUSH_FP,
      ST_POP_FP,
      ST_POP_RA,
      ST_COMMIT,
      ST_DONE
   } fseq_state_e;

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
   import fseq_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_i,
   input  fseq_op_e    op_i,
   input  logic        vec_i,
   input  logic        ack_i,
   output fseq_state_e state_o,
   output logic        accept_o,
   output logic        step_o,
   output logic        mem_req_o,
   output logic        mem_we_o,
   output logic        wb_en_o,
   output logic        done_o
);

   fseq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (go_i) begin
               unique case (op_i)
                  OP_RETURN: state_d = ST_POP_FP;
                  OP_TRAP:   state_d = vec_i ? ST_PUSH_RA : ST_COMMIT;
                  default:   state_d = ST_PUSH_RA;
               endcase
            end
         end
         ST_PUSH_RA: if (ack_i) state_d = ST_PUSH_FP;
         ST_PUSH_FP: if (ack_i) state_d = ST_COMMIT;
         ST_POP_FP:  if (ack_i) state_d = ST_POP_RA;
         ST_POP_RA:  if (ack_i) state_d = ST_COMMIT;
         ST_COMMIT:  state_d = ST_DONE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign mem_req_o = (state_q == ST_PUSH_RA) || (state_q == ST_PUSH_FP) ||
                      (state_q == ST_POP_FP)  || (state_q == ST_POP_RA);
   assign mem_we_o  = (state_q == ST_PUSH_RA) || (state_q == ST_PUSH_FP);
   assign accept_o  = go_i && (state_q == ST_IDLE);
   assign step_o    = ack_i && mem_req_o;
   assign wb_en_o   = (state_q == ST_COMMIT);
   assign done_o    = (state_q == ST_DONE);
   assign state_o   = state_q;

endmodule

// File: rtl/fseq_frame.sv
module fseq_frame
   import fseq_pkg::*;
#(
   parameter int                DATA_W       = 32,
   parameter int                ABS_CALL_LEN = 6,
   parameter int                REG_CALL_LEN = 2,
   parameter int                TRAP_LEN     = 6,
   parameter logic [DATA_W-1:0] VECTOR_CODE  = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              step_i,
   input  fseq_state_e       state_i,
   input  fseq_op_e          op_i,
   input  logic [DATA_W-1:0] pc_i,
   input  logic [DATA_W-1:0] target_i,
   input  logic [DATA_W-1:0] handler_i,
   input  logic [DATA_W-1:0] code_i,
   input  logic [DATA_W-1:0] sp_i,
   input  logic [DATA_W-1:0] fp_i,
   input  logic [DATA_W-1:0] rd_word_i,
   output logic              vec_o,
   output logic [DATA_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [DATA_W-1:0] new_sp_o,
   output logic [DATA_W-1:0] new_fp_o,
   output logic [DATA_W-1:0] new_pc_o,
   output logic [DATA_W-1:0] code_o,
   output logic              trap_o
);

   localparam int                WORD_BYTES = DATA_W / 8;
   localparam logic [DATA_W-1:0] OFS_W1     = DATA_W'(WORD_BYTES);
   localparam logic [DATA_W-1:0] OFS_W2     = DATA_W'(2 * WORD_BYTES);
   localparam logic [DATA_W-1:0] OFS_W3     = DATA_W'(3 * WORD_BYTES);
   localparam logic [DATA_W-1:0] LEN_ABS    = DATA_W'(ABS_CALL_LEN);
   localparam logic [DATA_W-1:0] LEN_REG    = DATA_W'(REG_CALL_LEN);
   localparam logic [DATA_W-1:0] LEN_TRAP   = DATA_W'(TRAP_LEN);

   logic [DATA_W-1:0] base_d, link_d, sp_d, fp_d, pc_d;
   logic [DATA_W-1:0] base_q, link_q, oldfp_q, sp_q, fp_q, pc_q, code_q;
   logic              trap_q;

   assign vec_o = (code_i == VECTOR_CODE);

   // Frame geometry chosen at the moment the operation is accepted
   always_comb begin
      base_d = sp_i;
      link_d = pc_i + LEN_ABS;
      sp_d   = sp_i - OFS_W3;
      fp_d   = sp_i - OFS_W3;
      pc_d   = target_i;
      unique case (op_i)
         OP_CALL_ABS: ;
         OP_CALL_REG: link_d = pc_i + LEN_REG;
         OP_RETURN: begin
            base_d = fp_i;
            sp_d   = fp_i + OFS_W3;
            fp_d   = fp_i;
            pc_d   = pc_i;
         end
         default: begin
            link_d = pc_i + LEN_TRAP;
            if (vec_o) begin
               pc_d = handler_i;
            end else begin
               sp_d = sp_i;
               fp_d = fp_i;
               pc_d = pc_i + LEN_TRAP;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q  <= '0;
         link_q  <= '0;
         oldfp_q <= '0;
         sp_q    <= '0;
         fp_q    <= '0;
         pc_q    <= '0;
         code_q  <= '0;
         trap_q  <= 1'b0;
      end else if (accept_i) begin
         base_q  <= base_d;
         link_q  <= link_d;
         oldfp_q <= fp_i;
         sp_q    <= sp_d;
         fp_q    <= fp_d;
         pc_q    <= pc_d;
         code_q  <= code_i;
         trap_q  <= (op_i == OP_TRAP);
      end else if (step_i) begin
         if (state_i == ST_POP_FP) fp_q <= rd_word_i;
         if (state_i == ST_POP_RA) pc_q <= rd_word_i;
      end
   end

   always_comb begin
      unique case (state_i)
         ST_PUSH_RA: addr_o = base_q - OFS_W2;
         ST_PUSH_FP: addr_o = base_q - OFS_W3;
         ST_POP_RA:  addr_o = base_q + OFS_W1;
         default:    addr_o = base_q;
      endcase
   end

   assign wdata_o  = (state_i == ST_PUSH_FP) ? oldfp_q : link_q;
   assign new_sp_o = sp_q;
   assign new_fp_o = fp_q;
   assign new_pc_o = pc_q;
   assign code_o   = code_q;
   assign trap_o   = trap_q;

endmodule

// File: rtl/fseq_lanes.sv
module fseq_lanes #(
   parameter int DATA_W    = 32,
   parameter bit LANE_SWAP = 1'b0
) (
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int NBYTES = DATA_W / 8;

   generate
      if (LANE_SWAP) begin : g_swap
         for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign bus_wdata_o[8*b +: 8] = wdata_i[DATA_W-8-8*b +: 8];
            assign rdata_o[8*b +: 8]     = bus_rdata_i[DATA_W-8-8*b +: 8];
         end
      end else begin : g_native
         assign bus_wdata_o = wdata_i;
         assign rdata_o     = bus_rdata_i;
      end
   endgenerate

endmodule

// File: rtl/call_frame_seq.sv
module call_frame_seq
   import fseq_pkg::*;
#(
   parameter int                DATA_W       = 32,
   parameter int                ABS_CALL_LEN = 6,
   parameter int                REG_CALL_LEN = 2,
   parameter int                TRAP_LEN     = 6,
   parameter int                TRAP_CAUSE   = 3,
   parameter logic [DATA_W-1:0] VECTOR_CODE  = '1,
   parameter bit                LANE_SWAP    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_go,
   input  logic [1:0]        frame_op,
   input  logic [DATA_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] jump_target,
   input  logic [DATA_W-1:0] vector_base,
   input  logic [DATA_W-1:0] trap_code,
   input  logic [DATA_W-1:0] cur_sp,
   input  logic [DATA_W-1:0] cur_fp,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_sp,
   output logic [DATA_W-1:0] wb_fp,
   output logic [DATA_W-1:0] wb_pc,
   output logic              sr_we,
   output logic [DATA_W-1:0] sr_cause,
   output logic [DATA_W-1:0] sr_code,
   output logic              done
);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_width
         $error("call_frame_seq: DATA_W must be a multiple of 8 and at least 16");
      end
      if (ABS_CALL_LEN <= 0 || REG_CALL_LEN <= 0 || TRAP_LEN <= 0) begin : g_bad_len
         $error("call_frame_seq: instruction lengths must be positive");
      end
      if (TRAP_CAUSE < 0) begin : g_bad_cause
         $error("call_frame_seq: TRAP_CAUSE must not be negative");
      end
   endgenerate

   fseq_state_e       state;
   fseq_op_e          op_sel;
   logic              accept, step, vec, trap_flag;
   logic [DATA_W-1:0] word_out, word_in;

   assign op_sel = fseq_op_e'(frame_op);

   fseq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (frame_go),
      .op_i      (op_sel),
      .vec_i     (vec),
      .ack_i     (mem_ack),
      .state_o   (state),
      .accept_o  (accept),
      .step_o    (step),
      .mem_req_o (mem_req),
      .mem_we_o  (mem_we),
      .wb_en_o   (wb_en),
      .done_o    (done)
   );

   fseq_frame #(
      .DATA_W       (DATA_W),
      .ABS_CALL_LEN (ABS_CALL_LEN),
      .REG_CALL_LEN (REG_CALL_LEN),
      .TRAP_LEN     (TRAP_LEN),
      .VECTOR_CODE  (VECTOR_CODE)
   ) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept_i  (accept),
      .step_i    (step),
      .state_i   (state),
      .op_i      (op_sel),
      .pc_i      (cur_pc),
      .target_i  (jump_target),
      .handler_i (vector_base),
      .code_i    (trap_code),
      .sp_i      (cur_sp),
      .fp_i      (cur_fp),
      .rd_word_i (word_in),
      .vec_o     (vec),
      .addr_o    (mem_addr),
      .wdata_o   (word_out),
      .new_sp_o  (wb_sp),
      .new_fp_o  (wb_fp),
      .new_pc_o  (wb_pc),
      .code_o    (sr_code),
      .trap_o    (trap_flag)
   );

   fseq_lanes #(
      .DATA_W    (DATA_W),
      .LANE_SWAP (LANE_SWAP)
   ) u_lanes (
      .wdata_i     (word_out),
      .bus_rdata_i (mem_rdata),
      .bus_wdata_o (mem_wdata),
      .rdata_o     (word_in)
   );

   assign sr_we    = wb_en && trap_flag;
   assign sr_cause = DATA_W'(TRAP_CAUSE);

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              wb_en,
   input logic              sr_we,
   input logic              done
);

   localparam int ALIGN_BITS = $clog2(DATA_W / 8);

   // R7: a pending request keeps its fields until acknowledged
   a_r7_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   // R7: word-aligned addresses, given aligned SP and FP
   a_r7_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[ALIGN_BITS-1:0] == '0));

   // R8: done follows the write-back strobe by one cycle
   a_r8_done_follows_wb: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |=> (done && !wb_en));

   a_r8_done_has_wb: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(wb_en));

   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: special-register update only inside write-back
   a_r6_sr_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
      sr_we |-> wb_en);

   // R7: no memory traffic while results are being written back
   a_r7_quiet_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_en || done) |-> !mem_req);

endmodule

bind call_frame_seq fseq_chk #(.DATA_W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack),
   .wb_en     (wb_en),
   .sr_we     (sr_we),
   .done      (done)
);

// File: tb/test_call_frame_seq.sv
module test_call_frame_seq;

   logic        clk = 1'b0, rst_n = 1'b0, go = 1'b0;
   logic [1:0]  op = 2'b00;
   logic [31:0] pc = '0, tgt = '0, hdl = '0, code = '0, sp = '0, fp = '0;
   logic        mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic        wb_en, sr_we, done;
   logic [31:0] wb_sp, wb_fp, wb_pc, sr_cause, sr_code;

   int n_chk = 0, n_err = 0;
   logic [31:0] mem [int unsigned];
   logic        log_we   [8];
   logic [31:0] log_addr [8];
   logic [31:0] log_data [8];
   int          log_n = 0, ack_wait = 0;

   always #4 clk = ~clk;

   call_frame_seq i_call_frame_seq (
      .clk(clk), .rst_n(rst_n), .frame_go(go), .frame_op(op),
      .cur_pc(pc), .jump_target(tgt), .vector_base(hdl), .trap_code(code),
      .cur_sp(sp), .cur_fp(fp),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .wb_en(wb_en), .wb_sp(wb_sp), .wb_fp(wb_fp), .wb_pc(wb_pc),
      .sr_we(sr_we), .sr_cause(sr_cause), .sr_code(sr_code), .done(done)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   // Memory model: one-cycle acknowledge after a random 0..3 cycle wait
   initial begin
      forever begin
         @(negedge clk);
         if (mem_ack) mem_ack = 1'b0;
         else if (mem_req) begin
            if (ack_wait > 0) ack_wait--;
            else begin
               if (log_n < 8) begin
                  log_we[log_n]   = mem_we;
                  log_addr[log_n] = mem_addr;
                  log_data[log_n] = mem_we ? mem_wdata :
                                    (mem.exists(mem_addr) ? mem[mem_addr] : 32'h0);
               end
               log_n++;
               if (mem_we) mem[mem_addr] = mem_wdata;
               else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
               mem_ack  = 1'b1;
               ack_wait = int'($urandom_range(0, 3));
            end
         end
      end
   end

   initial begin
      #(8 * 150000);
      n_err++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      report();
   end

   task automatic run_op(logic [1:0] o, logic [31:0] p, logic [31:0] t, logic [31:0] h,
                         logic [31:0] c, logic [31:0] s, logic [31:0] f, bit poke);
      string       rq, fr;
      bit          frame, got;
      int          exp_n;
      logic [31:0] e_sp, e_fp, e_pc, link, r_sp, r_fp, r_pc, r_code;
      logic        r_sr;
      rq = (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : (o == 2'b10) ? "R4" : "R5";
      if (o == 2'b10) begin
         if (!mem.exists(f))        mem[f]        = $urandom;
         if (!mem.exists(f + 32'd4)) mem[f + 32'd4] = $urandom;
      end
      frame = (o == 2'b00) || (o == 2'b01) || (o == 2'b11 && c == 32'hFFFF_FFFF);
      link  = p + ((o == 2'b01) ? 32'd2 : 32'd6);
      if (frame) begin
         e_sp = s - 32'd12; e_fp = s - 32'd12;
         e_pc = (o == 2'b11) ? h : t;
         exp_n = 2;
      end else if (o == 2'b10) begin
         e_sp = f + 32'd12; e_fp = mem[f]; e_pc = mem[f + 32'd4];
         exp_n = 2;
      end else begin
         e_sp = s; e_fp = f; e_pc = p + 32'd6;
         exp_n = 0;
      end
      log_n = 0;
      got = 1'b0;
      r_sp = '0; r_fp = '0; r_pc = '0; r_code = '0; r_sr = 1'b0;
      @(negedge clk);
      op = o; pc = p; tgt = t; hdl = h; code = c; sp = s; fp = f; go = 1'b1;
      for (int k = 0; k < 100; k++) begin
         @(negedge clk);
         go = poke && (k == 0);
         if (poke && k == 0) begin
            // R9: a second start while busy, with different operands
            op = ~o; pc = p ^ 32'h40; tgt = ~t; sp = s + 32'h100; fp = f + 32'h100;
            code = ~c; hdl = ~h;
         end
         if (wb_en) begin
            got = 1'b1;
            r_sp = wb_sp; r_fp = wb_fp; r_pc = wb_pc; r_sr = sr_we; r_code = sr_code;
            chk("R6", "sr_cause", (o == 2'b11) ? sr_cause : 32'd3, 32'd3);
            break;
         end
      end
      chk("R8", "write-back seen", {31'd0, got}, 32'd1);
      @(negedge clk);
      go = 1'b0;
      chk("R8", "done after wb", {30'd0, done, wb_en}, 32'd2);
      @(negedge clk);
      chk("R8", "done single", {31'd0, done}, 32'd0);
      chk(poke ? "R9" : "R3", "new sp", r_sp, e_sp);
      chk(poke ? "R9" : "R3", "new fp", r_fp, e_fp);
      chk(poke ? "R9" : rq, "next pc", r_pc, e_pc);
      chk("R6", "sr_we", {31'd0, r_sr}, {31'd0, (o == 2'b11)});
      if (o == 2'b11) chk("R6", "sr_code", r_code, c);
      chk("R7", "access count", 32'(log_n), 32'(exp_n));
      fr = frame ? rq : "R4";
      if (exp_n == 2 && log_n == 2) begin
         if (frame) begin
            chk(fr, "1st access write", {31'd0, log_we[0]}, 32'd1);
            chk(fr, "1st addr", log_addr[0], s - 32'd8);
            chk(fr, "return address", log_data[0], link);
            chk(fr, "2nd access write", {31'd0, log_we[1]}, 32'd1);
            chk(fr, "2nd addr", log_addr[1], s - 32'd12);
            chk(fr, "saved fp", log_data[1], f);
         end else begin
            chk("R4", "1st access read", {31'd0, log_we[0]}, 32'd0);
            chk("R4", "1st addr", log_addr[0], f);
            chk("R4", "2nd access read", {31'd0, log_we[1]}, 32'd0);
            chk("R4", "2nd addr", log_addr[1], f + 32'd4);
         end
      end
   endtask

   function automatic logic [31:0] rnd_ptr();
      return 32'h0000_4000 + (32'($urandom_range(0, 1023)) << 2);
   endfunction

   initial begin
      logic [31:0] rc;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R10: quiet outputs under reset
      chk("R10", "outputs in reset", {28'd0, mem_req, wb_en, sr_we, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10", "outputs after reset", {28'd0, mem_req, wb_en, sr_we, done}, 32'd0);

      // Round trip: absolute call, then return restores the caller
      run_op(2'b00, 32'h400, 32'h800, 32'h0, 32'h0, 32'h2000, 32'h2100, 1'b0);
      run_op(2'b10, 32'h900, 32'h0, 32'h0, 32'h0, 32'h1FC0, 32'h1FF4, 1'b0);
      chk("R4", "round trip pc", wb_pc, 32'h406);
      chk("R4", "round trip fp", wb_fp, 32'h2100);
      chk("R4", "round trip sp", wb_sp, 32'h2000);
      run_op(2'b01, 32'h1230, 32'h5550, 32'h0, 32'h0, 32'h3000, 32'h3010, 1'b0);
      run_op(2'b11, 32'h700, 32'h0, 32'hC000, 32'hFFFF_FFFF, 32'h2800, 32'h2810, 1'b0);
      run_op(2'b11, 32'h700, 32'h0, 32'hC000, 32'h0000_0005, 32'h2800, 32'h2810, 1'b0);
      run_op(2'b11, 32'h704, 32'h0, 32'hC000, 32'h0000_0001, 32'h2800, 32'h2810, 1'b1);
      run_op(2'b00, 32'h400, 32'h880, 32'h0, 32'h0, 32'h2400, 32'h2500, 1'b1);
      run_op(2'b10, 32'h400, 32'h0, 32'h0, 32'h0, 32'h2400, 32'h23F4, 1'b1);

      for (int i = 0; i < 60; i++) begin
         rc = ($urandom_range(0, 2) == 0) ? 32'hFFFF_FFFF : $urandom;
         run_op(2'($urandom_range(0, 3)), $urandom & 32'hFFFF_FFFE, $urandom, $urandom,
                rc, rnd_ptr(), rnd_ptr(), ($urandom_range(0, 4) == 0));
      end
      report();
   end

endmodule